// File: doc/BRIEF.md
# Ethernet PHY Mode Configuration Sequencer

This block brings an Ethernet PHY into a chosen speed and duplex setting by itself, with no software involved. On a start pulse it runs a short, fixed list of register writes over a two-wire management bus. Each write is a complete serial write frame. The block produces the management clock itself. It drives the data line through a pad, using an output value and an output enable.

The `mode` input picks the list of writes. In forced mode, a single write to the control register turns autonegotiation off and fixes the link at 100 Mb/s full duplex. In restricted-advertise mode, autonegotiation stays on, but only the two 100 Mb/s abilities are offered:
- The advertisement register is rewritten first.
- On a gigabit-capable PHY, the gigabit advertisement is then cleared. A parameter enables this step.
- The control register is written last, with soft reset and restart set, so that the new advertisement takes effect.

The host sees `busy` while the writes run. A one-cycle `done` marks the end of the sequence. `error` reports a start request that was refused because a sequence was already running.

Top module: `phy_mode_cfg`

## Requirements
- R1: Each write is a 64-bit frame sent MSB first, in this order:
  - 32 ones;
  - the start pattern 01;
  - the write opcode 01;
  - the 5-bit PHY address;
  - the 5-bit register number;
  - the turnaround pattern 10;
  - the 16 data bits.
- R2: `mdc` runs at the clock frequency divided by CLK_DIV (an even value of at least 4) and stays low while idle. `mdio_out` never changes while `mdc` is high or at its rising edge.
- R3: When `mode`=0 (forced), the sequence is one write of 0xA100 to register 0. This word has reset (bit 15), speed LSB (bit 13) and full duplex (bit 8) set, and speed MSB (bit 6) and autonegotiation enable (bit 12) clear.
- R4: When `mode`=1 and GIG_CAPABLE=0, the sequence is two writes, in this order:
  - register 4 = 0x0181 (selector 00001 in bits 4:0, 100 Mb/s half duplex in bit 7, 100 Mb/s full duplex in bit 8);
  - register 0 = 0x9200 (reset, autonegotiation enable, restart).
- R5: When `mode`=1 and GIG_CAPABLE=1, a write of 0x0000 to register 9 is placed between the two writes of R4. This word has bits 9 and 8 clear.
- R6: `mdio_oe` is high only while the block is busy. It is low from the cycle in which `done` is high.
- R7: `busy` goes high in the cycle after an accepted start. It goes low in the same cycle in which `done` pulses high, and `done` lasts exactly one cycle.
- R8: A start received while busy is ignored, and the running sequence completes unchanged. `error` goes high in the next cycle and stays high until the next accepted start clears it.
- R9: `mode` and `phy_addr` are captured when a start is accepted. Changes to them during a run have no effect on that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to run the configuration sequence |
| mode | input | 1 | 0 = forced 100 Mb/s full duplex, 1 = restricted advertisement |
| phy_addr | input | 5 | Management address of the target PHY |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Data bit for the management data pad |
| mdio_oe | output | 1 | Pad output enable; low releases the line |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse at the end of the last frame |
| error | output | 1 | A start was refused while busy |

## Verification
Some properties hold at every clock edge, and the embedded assertions check those:
- the data bit holds still through the high phase of the management clock;
- `done` is a single cycle and coincides with `busy` falling;
- the line is released at `done`;
- a frame load never lands on a frame that is still shifting;
- a start during a run always raises `error` and leaves the captured mode and address untouched.

The exact words, register numbers, frame fields and write order can only be shown by the bench. It decodes every frame seen on the bus for each address in both modes and both gigabit settings, and compares them with frames assembled from R1 and R3 to R5. The bench also measures the clock period and checks what happens when a start is refused in the middle of a run.

// File: rtl/phy_cfg_pkg.sv
package phy_cfg_pkg;

    typedef enum logic {
        MODE_FORCED = 1'b0,
        MODE_ADV    = 1'b1
    } cfg_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_WAIT = 2'd2
    } seq_state_e;

    // One management register write: register number and data word
    typedef struct packed {
        logic [4:0]  regad;
        logic [15:0] data;
    } mgmt_wr_t;

    localparam int FRAME_W    = 64;
    localparam int PREAMBLE_W = 32;
    localparam logic [1:0] SOF_PAT = 2'b01;
    localparam logic [1:0] OP_WR   = 2'b01;
    localparam logic [1:0] TA_PAT  = 2'b10;

    localparam logic [4:0] REG_CTRL = 5'd0;
    localparam logic [4:0] REG_ADV  = 5'd4;
    localparam logic [4:0] REG_GIG  = 5'd9;

    // Control register bit positions
    localparam int C_RESET   = 15;
    localparam int C_SPD_LSB = 13;
    localparam int C_AN_EN   = 12;
    localparam int C_AN_RST  = 9;
    localparam int C_DUPLEX  = 8;
    localparam int C_SPD_MSB = 6;

    // Speed code {msb,lsb}: 01 selects 100 Mb/s
    localparam logic [1:0] SPEED_100 = 2'b01;

    // Advertisement register fields
    localparam int A_100FD = 8;
    localparam int A_100HD = 7;
    localparam logic [4:0] A_SELECTOR = 5'b00001;

    // Gigabit advertisement bits to clear
    localparam int G_1000FD = 9;
    localparam int G_1000HD = 8;

    function automatic logic [15:0] ctrl_forced_word();
        logic [15:0] w;
        w = '0;
        w[C_RESET]   = 1'b1;
        w[C_SPD_MSB] = SPEED_100[1];
        w[C_SPD_LSB] = SPEED_100[0];
        w[C_AN_EN]   = 1'b0;
        w[C_DUPLEX]  = 1'b1;
        return w;
    endfunction

    function automatic logic [15:0] ctrl_restart_word();
        logic [15:0] w;
        w = '0;
        w[C_RESET]  = 1'b1;
        w[C_AN_EN]  = 1'b1;
        w[C_AN_RST] = 1'b1;
        return w;
    endfunction

    function automatic logic [15:0] adv_word();
        logic [15:0] w;
        w = '0;
        w[4:0]     = A_SELECTOR;
        w[A_100FD] = 1'b1;
        w[A_100HD] = 1'b1;
        return w;
    endfunction

    function automatic logic [15:0] gig_word();
        logic [15:0] w;
        w = '0;
        w[G_1000FD] = 1'b0;
        w[G_1000HD] = 1'b0;
        return w;
    endfunction

    // Number of writes in the sequence for a mode
    function automatic logic [1:0] seq_len(cfg_mode_e m, logic gig);
        if (m == MODE_FORCED) return 2'd1;
        return gig ? 2'd3 : 2'd2;
    endfunction

    // Write issued at a given position of the sequence
    function automatic mgmt_wr_t seq_entry(cfg_mode_e m, logic gig, logic [1:0] idx);
        mgmt_wr_t w;
        w.regad = REG_CTRL;
        w.data  = ctrl_forced_word();
        if (m == MODE_ADV) begin
            if (idx == 2'd0) begin
                w.regad = REG_ADV;
                w.data  = adv_word();
            end else if (gig && idx == 2'd1) begin
                w.regad = REG_GIG;
                w.data  = gig_word();
            end else begin
                w.regad = REG_CTRL;
                w.data  = ctrl_restart_word();
            end
        end
        return w;
    endfunction

    function automatic logic [FRAME_W-1:0] build_frame(logic [4:0] phy, mgmt_wr_t w);
        return {{PREAMBLE_W{1'b1}}, SOF_PAT, OP_WR, phy, w.regad, TA_PAT, w.data};
    endfunction

endpackage

// File: rtl/mdc_divider.sv
module mdc_divider #(
    parameter int CLK_DIV = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic mdc,
    output logic fall_stb
);
    localparam int HALF = CLK_DIV / 2;
    localparam int CW   = $clog2(HALF) + 1;

    logic [CW-1:0] cnt_q;
    logic          wrap;

    assign wrap     = (cnt_q == CW'(HALF - 1));
    assign fall_stb = en && wrap && mdc;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            mdc   <= ~mdc;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R2: the management clock rests low whenever the divider is off
    assert_idle_low_R2: assert property (@(posedge clk) disable iff (rst)
        !en |=> !mdc)
        else $error("mdc not low while disabled");

endmodule

// File: rtl/mgmt_frame_shifter.sv
module mgmt_frame_shifter #(
    parameter int FRAME_W = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame,
    input  logic               fall_stb,
    output logic               bit_o,
    output logic               frame_done
);
    localparam int IW = $clog2(FRAME_W);

    logic [FRAME_W-1:0] sh_q;
    logic [IW-1:0]      idx_q;
    logic               act_q;
    logic               last_bit;

    assign last_bit   = (idx_q == IW'(FRAME_W - 1));
    assign frame_done = act_q && fall_stb && last_bit;
    assign bit_o      = sh_q[FRAME_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            idx_q <= '0;
            act_q <= 1'b0;
        end else if (load) begin
            sh_q  <= frame;
            idx_q <= '0;
            act_q <= 1'b1;
        end else if (act_q && fall_stb) begin
            if (last_bit) begin
                act_q <= 1'b0;
            end else begin
                sh_q  <= {sh_q[FRAME_W-2:0], 1'b0};
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // R1: a new frame is never loaded over one still being shifted
    assert_no_overlap_R1: assert property (@(posedge clk) disable iff (rst)
        load |-> !act_q)
        else $error("frame load while shifting");

endmodule

// File: rtl/cfg_step_ctrl.sv
module cfg_step_ctrl
    import phy_cfg_pkg::*;
#(
    parameter bit GIG_CAPABLE = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               mode_in,
    input  logic [4:0]         addr_in,
    input  logic               frame_done,
    output logic               load,
    output logic [FRAME_W-1:0] frame,
    output logic               busy,
    output logic               done,
    output logic               error
);
    seq_state_e state_q;
    cfg_mode_e  mode_q;
    logic [4:0] addr_q;
    logic [1:0] step_q;
    logic [1:0] len;
    logic       last_step;
    mgmt_wr_t   entry;

    assign len       = seq_len(mode_q, GIG_CAPABLE);
    assign last_step = (step_q == len - 2'd1);
    assign entry     = seq_entry(mode_q, GIG_CAPABLE, step_q);
    assign frame     = build_frame(addr_q, entry);
    assign load      = (state_q == ST_LOAD);
    assign busy      = (state_q != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            mode_q  <= MODE_FORCED;
            addr_q  <= '0;
            step_q  <= '0;
            done    <= 1'b0;
            error   <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        mode_q  <= cfg_mode_e'(mode_in);
                        addr_q  <= addr_in;
                        step_q  <= '0;
                        error   <= 1'b0;
                        state_q <= ST_LOAD;
                    end
                end
                ST_LOAD: state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (frame_done) begin
                        if (last_step) begin
                            state_q <= ST_IDLE;
                            done    <= 1'b1;
                        end else begin
                            step_q  <= step_q + 2'd1;
                            state_q <= ST_LOAD;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
            if (state_q != ST_IDLE && start) error <= 1'b1;
        end
    end

    // R7: done is a single-cycle pulse
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done)
        else $error("done longer than one cycle");

    // R7: busy only drops together with done
    assert_busy_end_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done)
        else $error("busy fell without done");

    // R8: a start during a run is reported
    assert_refused_start_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> error)
        else $error("refused start not flagged");

    // R9: captured mode and address hold through a refused start
    assert_capture_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> ($stable(mode_q) && $stable(addr_q)))
        else $error("captured settings changed during run");

    // R5: the step index stays inside the sequence
    assert_step_range_R5: assert property (@(posedge clk) disable iff (rst)
        busy |-> (step_q < len))
        else $error("step index beyond sequence");

endmodule

// File: rtl/phy_mode_cfg.sv
module phy_mode_cfg
    import phy_cfg_pkg::*;
#(
    parameter int CLK_DIV     = 40,
    parameter bit GIG_CAPABLE = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       mode,
    input  logic [4:0] phy_addr,
    output logic       mdc,
    output logic       mdio_out,
    output logic       mdio_oe,
    output logic       busy,
    output logic       done,
    output logic       error
);
    logic               fall_stb;
    logic               frame_done;
    logic               load;
    logic [FRAME_W-1:0] frame;

    cfg_step_ctrl #(
        .GIG_CAPABLE(GIG_CAPABLE)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .mode_in    (mode),
        .addr_in    (phy_addr),
        .frame_done (frame_done),
        .load       (load),
        .frame      (frame),
        .busy       (busy),
        .done       (done),
        .error      (error)
    );

    mdc_divider #(
        .CLK_DIV(CLK_DIV)
    ) u_div (
        .clk      (clk),
        .rst      (rst),
        .en       (busy),
        .mdc      (mdc),
        .fall_stb (fall_stb)
    );

    mgmt_frame_shifter #(
        .FRAME_W(FRAME_W)
    ) u_shift (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .frame      (frame),
        .fall_stb   (fall_stb),
        .bit_o      (mdio_out),
        .frame_done (frame_done)
    );

    assign mdio_oe = busy;

    // R2: data holds through the high phase of the management clock
    assert_data_stable_R2: assert property (@(posedge clk) disable iff (rst)
        mdc |-> $stable(mdio_out))
        else $error("mdio changed while mdc high");

    // R6: the line is released once the sequence ends
    assert_release_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> !mdio_oe)
        else $error("mdio still driven at done");

endmodule

// File: tb/phy_mode_cfg_test.sv
module phy_mode_cfg_test;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    always @(posedge clk) cyc++;

    // instance A: gigabit-capable; instance B: not
    logic       start_a = 0, mode_a = 0, start_b = 0, mode_b = 0;
    logic [4:0] addr_a = 0, addr_b = 0;
    logic mdc_a, mdio_a, oe_a, busy_a, done_a, err_a;
    logic mdc_b, mdio_b, oe_b, busy_b, done_b, err_b;

    phy_mode_cfg #(.CLK_DIV(DIV), .GIG_CAPABLE(1'b1)) uut (
        .clk(clk), .rst(rst), .start(start_a), .mode(mode_a), .phy_addr(addr_a),
        .mdc(mdc_a), .mdio_out(mdio_a), .mdio_oe(oe_a),
        .busy(busy_a), .done(done_a), .error(err_a));

    phy_mode_cfg #(.CLK_DIV(DIV), .GIG_CAPABLE(1'b0)) uut_ng (
        .clk(clk), .rst(rst), .start(start_b), .mode(mode_b), .phy_addr(addr_b),
        .mdc(mdc_b), .mdio_out(mdio_b), .mdio_oe(oe_b),
        .busy(busy_b), .done(done_b), .error(err_b));

    // frame capture, one set per instance
    logic [63:0] cap [2][4];
    int ncap [2], nbit [2], per_bad [2], hi_bad [2], last_rise [2];
    logic [63:0] shreg [2];
    logic pm [2], pd [2], po [2];

    task automatic grab(input int w, input logic d);
        shreg[w] = {shreg[w][62:0], d};
        if (nbit[w] == 63) begin
            if (ncap[w] < 4) cap[w][ncap[w]] = shreg[w];
            ncap[w]++;
            nbit[w] = 0;
        end else nbit[w]++;
        if (last_rise[w] >= 0 && (cyc - last_rise[w]) != DIV) per_bad[w]++;
        last_rise[w] = cyc;
    endtask

    always @(posedge mdc_a) if (oe_a) grab(0, mdio_a);
    always @(posedge mdc_b) if (oe_b) grab(1, mdio_b);

    // data must not move while mdc is high (including the rising edge)
    always @(negedge clk) begin
        if (oe_a && po[0] && mdc_a && mdio_a != pd[0]) hi_bad[0]++;
        if (oe_b && po[1] && mdc_b && mdio_b != pd[1]) hi_bad[1]++;
        pm[0] = mdc_a; pd[0] = mdio_a; po[0] = oe_a;
        pm[1] = mdc_b; pd[1] = mdio_b; po[1] = oe_b;
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_frame(logic [4:0] a, logic [4:0] r, logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, 2'b01, a, r, 2'b10, d};
    endfunction

    function automatic logic o_busy(int w);  return w == 0 ? busy_a : busy_b; endfunction
    function automatic logic o_done(int w);  return w == 0 ? done_a : done_b; endfunction
    function automatic logic o_err(int w);   return w == 0 ? err_a  : err_b;  endfunction
    function automatic logic o_oe(int w);    return w == 0 ? oe_a   : oe_b;   endfunction
    function automatic logic o_mdc(int w);   return w == 0 ? mdc_a  : mdc_b;  endfunction

    task automatic drive(input int w, input logic s, input logic m, input logic [4:0] a);
        if (w == 0) begin start_a = s; mode_a = m; addr_a = a; end
        else        begin start_b = s; mode_b = m; addr_b = a; end
    endtask

    task automatic run(input int w, input logic m, input logic [4:0] a, input bit mid);
        logic [4:0]  er [3];
        logic [15:0] ed [3];
        int en, guard;
        string tag;
        ncap[w] = 0; nbit[w] = 0; per_bad[w] = 0; hi_bad[w] = 0; last_rise[w] = -1;
        if (m == 1'b0) begin
            en = 1; er[0] = 5'd0; ed[0] = 16'h8000 | 16'h2000 | 16'h0100; tag = "R3";
        end else begin
            er[0] = 5'd4; ed[0] = 16'h0100 | 16'h0080 | 16'h0001;
            if (w == 0) begin
                en = 3; er[1] = 5'd9; ed[1] = 16'h0000;
                er[2] = 5'd0; ed[2] = 16'h8000 | 16'h1000 | 16'h0200; tag = "R5";
            end else begin
                en = 2; er[1] = 5'd0; ed[1] = 16'h8000 | 16'h1000 | 16'h0200; tag = "R4";
            end
        end
        if (mid) tag = {tag, " R9 R8"};
        @(negedge clk); drive(w, 1'b1, m, a);
        @(negedge clk); drive(w, 1'b0, m, a);
        check("R7 busy after start", 64'(o_busy(w)), 64'd1);
        check("R8 error cleared by accepted start", 64'(o_err(w)), 64'd0);
        if (mid) begin
            repeat (100) @(negedge clk);
            drive(w, 1'b1, ~m, ~a);
            @(negedge clk); drive(w, 1'b0, ~m, ~a);
            check("R8 error after refused start", 64'(o_err(w)), 64'd1);
            check("R8 still busy", 64'(o_busy(w)), 64'd1);
        end
        guard = 0;
        while (o_done(w) !== 1'b1 && guard < 6000) begin @(negedge clk); guard++; end
        check("R7 done reached", 64'(o_done(w)), 64'd1);
        check("R7 busy low with done", 64'(o_busy(w)), 64'd0);
        check("R6 released at done", 64'(o_oe(w)), 64'd0);
        @(negedge clk);
        check("R7 done one cycle", 64'(o_done(w)), 64'd0);
        check("R2 mdc low when idle", 64'(o_mdc(w)), 64'd0);
        check({tag, " frame count"}, 64'(ncap[w]), 64'(en));
        for (int i = 0; i < en && i < 4; i++)
            check({tag, " R1 frame content"}, cap[w][i], exp_frame(a, er[i], ed[i]));
        check("R2 mdc period", 64'(per_bad[w]), 64'd0);
        check("R2 data stable while mdc high", 64'(hi_bad[w]), 64'd0);
        if (mid) check("R8 error held after run", 64'(o_err(w)), 64'd1);
        drive(w, 1'b0, 1'b0, 5'd0);
    endtask

    initial begin
        for (int w = 0; w < 2; w++) begin
            ncap[w] = 0; nbit[w] = 0; per_bad[w] = 0; hi_bad[w] = 0; last_rise[w] = -1;
            shreg[w] = '0; pm[w] = 0; pd[w] = 0; po[w] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R7 reset busy", 64'(busy_a), 64'd0);
        check("R7 reset done", 64'(done_a), 64'd0);
        check("R6 reset oe", 64'(oe_a | oe_b), 64'd0);
        check("R2 reset mdc", 64'(mdc_a | mdc_b), 64'd0);
        check("R8 reset error", 64'(err_a | err_b), 64'd0);
        for (int a = 0; a < 32; a++) begin
            run(0, 1'b0, 5'(a), 1'b0);
            run(0, 1'b1, 5'(a), 1'b0);
            run(1, 1'b0, 5'(a), 1'b0);
            run(1, 1'b1, 5'(a), 1'b0);
        end
        run(0, 1'b1, 5'h0A, 1'b1);
        run(0, 1'b0, 5'h15, 1'b0);
        run(1, 1'b0, 5'h1F, 1'b1);
        run(1, 1'b1, 5'h03, 1'b0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait (cyc >= 150000);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected<150000", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule